// File: doc/BRIEF.md
# Signed four-term dot product with digit-split coefficients

This block multiplies four signed 16-bit coefficients by four signed 16-bit data words and adds the four products. The result is one wide signed word. Each coefficient is cut into four 4-bit digits. Each digit is multiplied by its data word in a small carry-save array that produces a sum word and a carry word and has no adder of its own. The sixteen digit products give 32 words. These are shifted to their weight, merged in one tree of 4:2 compressors and resolved by a single lookahead adder.

Signs are handled in two's complement form. Any partial-product bit that pairs exactly one sign bit with an ordinary bit is inverted. The bit that pairs the two sign bits is not inverted. A fixed correction constant, computed from the parameters, restores the true value. The result goes through one register. Inputs applied before a rising edge appear at the output right after that edge.

Top module: `dp_inner_product`

## Requirements
- R1: While `rst_n` is low, `result` is 0 whatever the inputs are.
- R2: After every rising edge with `rst_n` high, `result` equals the exact signed sum over k = 0..3 of `coef[k]` × `data[k]`, using the inputs present at that edge. `coef[k]` is bits [16k+15:16k] of `coef`, and `data[k]` is the same bit range of `data`.
- R3: When every coefficient and every data word is -32768, the result is +2^32 (0x1_0000_0000 in 35 bits), with bit 34 clear.
- R4: When every coefficient is +32767 and every data word is -32768, the result is -4294836224. The same value results with the two operands swapped.
- R5: Negative results are fully sign-extended across all 35 bits. For example, coefficient 1 with data -1 in one pair, and zeros elsewhere, gives all 35 bits set.
- R6: When every coefficient is zero, the result is zero for any data, and the data has no effect.
- R7: Each pair contributes on its own. With only pair k nonzero, the result equals that pair's signed product, for each k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coef | input | 64 | Four signed 16-bit coefficients packed side by side; pair k in bits [16k+15:16k] |
| data | input | 64 | Four signed 16-bit data words, packed the same way |
| result | output | 35 | Registered signed dot product |

## Verification
The bench goes after the places where the sign handling can slip. In the all-minimum case, the product of two sign bits must end up as a large positive value. A wrong gate type on the sign-times-sign bit, or a missing correction constant, would flip bit 34 or shift the value by a power of two. Mixed-extreme operands and small negative results check that the correction is sign-extended over the full width. Without that, the top bits would come out clear. Single-pair tests and zero coefficients catch a digit term placed at the wrong weight, or one that is lost in the compressor tree. Constrained random vectors, biased toward extreme values, cover carries that run across the 4-bit digit borders.

// File: rtl/dp_pkg.sv
package dp_pkg;
    // Default geometry: pairs, word length, digit width
    localparam int unsigned DP_PAIRS = 4;
    localparam int unsigned DP_WORD  = 16;
    localparam int unsigned DP_DIGIT = 4;

    // Correction for the inverted mixed-sign bits, summed over all pairs
    function automatic longint dp_correction(input int unsigned pairs, input int unsigned word);
        longint per_pair;
        per_pair = (longint'(1) <<< word) - (longint'(1) <<< (2 * word - 1));
        return longint'(pairs) * per_pair;
    endfunction
endpackage

// File: rtl/dp_digit_mul.sv
module dp_digit_mul #(
    parameter int unsigned B    = 16,
    parameter int unsigned DIG  = 4,
    parameter int unsigned RIDX = 0,
    localparam int unsigned DW  = B + DIG
) (
    input  logic [DIG-1:0] udig,
    input  logic [B-1:0]   vword,
    output logic [DW-1:0]  sum_w,
    output logic [DW-1:0]  car_w
);
    logic [DW-1:0] rows [DIG];

    // Partial-product rows; mixed sign pairs are inverted
    always_comb begin
        for (int i = 0; i < DIG; i++) begin
            rows[i] = '0;
            for (int j = 0; j < B; j++) begin
                logic usgn, vsgn, pp;
                usgn = ((RIDX * DIG + i) == (B - 1));
                vsgn = (j == (B - 1));
                pp   = udig[i] & vword[j];
                rows[i][i+j] = (usgn ^ vsgn) ? ~pp : pp;
            end
        end
    end

    // Carry-save reduction of the rows, no final adder
    always_comb begin
        logic [DW-1:0] s, c, ns, nc;
        s = rows[0];
        c = rows[1];
        for (int i = 2; i < DIG; i++) begin
            ns = s ^ c ^ rows[i];
            nc = ((s & c) | (s & rows[i]) | (c & rows[i])) << 1;
            s  = ns;
            c  = nc;
        end
        sum_w = s;
        car_w = c;
    end
endmodule

// File: rtl/dp_csa42.sv
module dp_csa42 #(
    parameter int unsigned W = 35
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] d,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);
    logic [W-1:0] s1, c1;

    // First row: the slow xor path feeds the carry input of the second row
    always_comb begin
        s1 = a ^ b ^ c;
        c1 = ((a & b) | (a & c) | (b & c)) << 1;
        s  = s1 ^ d ^ c1;
        cy = ((s1 & d) | (s1 & c1) | (d & c1)) << 1;
    end
endmodule

// File: rtl/dp_cla.sv
module dp_cla #(
    parameter int unsigned WIDTH = 35,
    parameter int unsigned GRP   = 4,
    localparam int unsigned NG   = (WIDTH + GRP - 1) / GRP
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum
);
    logic [WIDTH-1:0] g, p, cb;
    logic [NG-1:0]    cg;

    always_comb begin
        logic gg, pp, cc;
        g = a & b;
        p = a ^ b;
        cg = '0;
        // Group generate/propagate and carries between groups
        for (int k = 0; k < NG - 1; k++) begin
            gg = 1'b0;
            pp = 1'b1;
            for (int m = 0; m < GRP; m++) begin
                if (k * GRP + m < WIDTH) begin
                    gg = g[k*GRP+m] | (p[k*GRP+m] & gg);
                    pp = pp & p[k*GRP+m];
                end
            end
            cg[k+1] = gg | (pp & cg[k]);
        end
        // Bit carries inside each group
        cb = '0;
        for (int k = 0; k < NG; k++) begin
            cc = cg[k];
            for (int m = 0; m < GRP; m++) begin
                if (k * GRP + m < WIDTH) begin
                    cb[k*GRP+m] = cc;
                    cc = g[k*GRP+m] | (p[k*GRP+m] & cc);
                end
            end
        end
        sum = p ^ cb;
    end
endmodule

// File: rtl/dp_inner_product.sv
module dp_inner_product #(
    parameter int unsigned NP  = dp_pkg::DP_PAIRS,
    parameter int unsigned B   = dp_pkg::DP_WORD,
    parameter int unsigned DIG = dp_pkg::DP_DIGIT,
    localparam int unsigned K      = B / DIG,
    localparam int unsigned W      = 2 * B + $clog2(NP) + 1,
    localparam int unsigned DW     = B + DIG,
    localparam int unsigned NWORDS = 2 * NP * K,
    localparam int unsigned LV     = $clog2(NWORDS) - 1,
    localparam int unsigned NNODE  = 2 * NWORDS - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NP-1:0][B-1:0]  coef,
    input  logic [NP-1:0][B-1:0]  data,
    output logic signed [W-1:0]   result
);
    localparam longint CORR_L = dp_pkg::dp_correction(NP, B);
    localparam logic [W-1:0] CORR = W'(CORR_L);

    typedef struct packed {
        logic signed [W-1:0] result;
    } state_t;

    state_t st_d, st_q;

    // Flat node array: level 0 holds the weighted digit words, each
    // compressor level appends half as many words after it
    logic [W-1:0] node [NNODE];

    for (genvar gp = 0; gp < NP; gp++) begin : g_pair
        for (genvar gr = 0; gr < K; gr++) begin : g_digit
            logic [DW-1:0] ds, dc;
            dp_digit_mul #(.B(B), .DIG(DIG), .RIDX(gr)) u_mul (
                .udig  (coef[gp][gr*DIG +: DIG]),
                .vword (data[gp]),
                .sum_w (ds),
                .car_w (dc)
            );
            assign node[2*(gp*K+gr)]   = W'(ds) << (gr * DIG);
            assign node[2*(gp*K+gr)+1] = W'(dc) << (gr * DIG);
        end
    end

    for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
        localparam int unsigned BI = 2 * NWORDS - ((2 * NWORDS) >> lv);
        localparam int unsigned BO = 2 * NWORDS - ((2 * NWORDS) >> (lv + 1));
        for (genvar c = 0; c < (NWORDS >> (lv + 2)); c++) begin : g_cmp
            dp_csa42 #(.W(W)) u_cmp (
                .a  (node[BI+4*c]),
                .b  (node[BI+4*c+1]),
                .c  (node[BI+4*c+2]),
                .d  (node[BI+4*c+3]),
                .s  (node[BO+2*c]),
                .cy (node[BO+2*c+1])
            );
        end
    end

    // Fold the correction constant in one carry-save row, then one adder
    logic [W-1:0] fx, fy, fsum;

    always_comb begin
        fx = node[NNODE-2] ^ node[NNODE-1] ^ CORR;
        fy = ((node[NNODE-2] & node[NNODE-1]) | (node[NNODE-2] & CORR)
              | (node[NNODE-1] & CORR)) << 1;
    end

    dp_cla #(.WIDTH(W), .GRP(DIG)) u_cla (
        .a   (fx),
        .b   (fy),
        .sum (fsum)
    );

    always_comb begin
        st_d = st_q;
        st_d.result = $signed(fsum);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.result;
endmodule

// File: rtl/dp_inner_product_chk.sv
module dp_inner_product_chk #(
    parameter int unsigned NP  = 4,
    parameter int unsigned B   = 16,
    parameter int unsigned DIG = 4,
    localparam int unsigned W  = 2 * B + $clog2(NP) + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NP-1:0][B-1:0] coef,
    input logic [NP-1:0][B-1:0] data,
    input logic signed [W-1:0]  result
);
    localparam longint BOUND = longint'(NP) <<< (2 * B - 2);

    function automatic longint ref_dot(input logic [NP-1:0][B-1:0] c, input logic [NP-1:0][B-1:0] d);
        longint acc;
        acc = 0;
        for (int k = 0; k < NP; k++) begin
            acc += longint'($signed(c[k])) * longint'($signed(d[k]));
        end
        return acc;
    endfunction

    logic all_min;
    always_comb begin
        all_min = 1'b1;
        for (int k = 0; k < NP; k++) begin
            if (coef[k] != {1'b1, {(B-1){1'b0}}} || data[k] != {1'b1, {(B-1){1'b0}}}) all_min = 1'b0;
        end
    end

    p_dot_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> longint'(result) == $past(ref_dot(coef, data)));

    p_all_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        all_min |=> (longint'(result) == (longint'(NP) <<< (2 * B - 2))) && !result[W-1]);

    p_zero_coef_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (coef == '0) |=> result == '0);

    p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(result) <= BOUND) && (longint'(result) >= -BOUND));
endmodule

bind dp_inner_product dp_inner_product_chk #(.NP(NP), .B(B), .DIG(DIG)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .coef   (coef),
    .data   (data),
    .result (result)
);

// File: tb/tb_dp_inner_product.sv
module tb_dp_inner_product;
    localparam int NP = 4;
    localparam int B  = 16;
    localparam int W  = 2 * B + $clog2(NP) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0][B-1:0] coef = '0;
    logic [NP-1:0][B-1:0] data = '0;
    logic signed [W-1:0]  result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    dp_inner_product dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .coef   (coef),
        .data   (data),
        .result (result)
    );

    function automatic logic signed [W-1:0] exp_dot(input logic [NP-1:0][B-1:0] c, input logic [NP-1:0][B-1:0] d);
        longint acc;
        acc = 0;
        for (int k = 0; k < NP; k++) begin
            acc += longint'($signed(c[k])) * longint'($signed(d[k]));
        end
        return W'(acc);
    endfunction

    task automatic check(input string req, input logic signed [W-1:0] act, input logic signed [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic apply(input logic [NP-1:0][B-1:0] c, input logic [NP-1:0][B-1:0] d, input string req);
        @(negedge clk);
        coef = c;
        data = d;
        @(posedge clk);
        #1;
        check(req, result, exp_dot(c, d));
    endtask

    function automatic logic [B-1:0] pick_word();
        logic [B-1:0] w;
        case ($urandom % 6)
            0: w = 16'h8000;
            1: w = 16'h7FFF;
            2: w = 16'hFFFF;
            default: w = B'($urandom);
        endcase
        return w;
    endfunction

    initial begin
        logic [NP-1:0][B-1:0] c, d;
        void'($urandom(32'd4242));

        // R1: reset holds result at zero despite nonzero inputs
        coef = {NP{16'h7FFF}};
        data = {NP{16'h8000}};
        repeat (3) @(posedge clk);
        #1;
        check("R1", result, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: all minimum
        apply({NP{16'h8000}}, {NP{16'h8000}}, "R3");
        check("R3 sign", W'(result[W-1]), '0);

        // R4: extreme mixed, both orders
        apply({NP{16'h7FFF}}, {NP{16'h8000}}, "R4");
        check("R4 value", result, -35'sd4294836224);
        apply({NP{16'h8000}}, {NP{16'h7FFF}}, "R4 swap");

        // R5: small negative result is sign-extended over all bits
        apply({16'h0, 16'h0, 16'h0, 16'h0001}, {16'h0, 16'h0, 16'h0, 16'hFFFF}, "R5");
        check("R5 all ones", result, {W{1'b1}});
        apply({16'hFFFF, 16'h0, 16'h0, 16'h0}, {16'h1234, 16'h0, 16'h0, 16'h0}, "R5 neg");

        // R6: zero coefficients ignore the data
        apply('0, {NP{16'h8000}}, "R6");
        apply('0, {16'h7FFF, 16'h1234, 16'hFFFF, 16'h8001}, "R6 mixed");
        check("R6 zero", result, '0);

        // R7: each pair alone
        for (int k = 0; k < NP; k++) begin
            c = '0;
            d = {NP{16'h5A5A}};
            c[k] = 16'h8001 + 16'(k);
            apply(c, d, "R7");
        end

        // R2: random biased toward extremes
        for (int n = 0; n < 400; n++) begin
            for (int k = 0; k < NP; k++) begin
                c[k] = pick_word();
                d[k] = pick_word();
            end
            apply(c, d, "R2");
        end

        // R1: reset returns result to zero
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 re-reset", result, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule